// File: doc/BRIEF.md
# Dual-Bank Flash Command Decoder

This block models the command side of a two-bank NOR-style flash. A host sends one address, a data word and a write strobe per write cycle. The block decodes short write sequences that start a word program, enter identification mode or return to normal reading. It keeps a small word array that stands in for the memory cells. Reads return, depending on the mode, array contents, identification bytes or a progress status word. A ready line goes low while an embedded program runs, and a cycle counter sets how long each program takes.

The address splits into a bank bit and an in-bank offset. The top address bit selects the bank, and the remaining bits form the offset that the command decoder compares. The storage array keeps only `BANK_WORDS` words per bank and is indexed by the bank bit and the low offset bits, so higher offsets alias onto the same words. Each command records which bank it belongs to. A program or an identification session in one bank leaves the other bank readable as plain array data. A program can only clear bits. An optional accelerated input turns any write in the read state into an immediate single-write program.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ready` is 1 and `rdata` is 0. Reset sets every array word to all ones and aborts a running program at once. The block then reads array data, and no command is needed first.
- R2: A read strobed at a clock edge updates `rdata` in the following cycle, and `rdata` holds between reads. The array word index is {address bit 11, address bits 3:0}.
- R3: Writing 0xAA at offset 0x555, then 0x55 at offset 0x2AA, then 0xA0 at any address, then a data word at the target address starts a program. Command bytes are the low data byte, and the offset is address bits 10:0. `ready` is 0 for exactly `PROG_CYCLES` cycles, starting in the cycle after the data write. The word is updated in the cycle in which `ready` returns to 1.
- R4: A write that does not match the next expected unlock or command cycle returns the decoder to the read state. The sequence must then start again from its first cycle.
- R5: Writing low byte 0xF0 ends identification mode. A following read of that bank returns array data. A 0xF0 inside an unlock sequence also returns to the read state.
- R6: After 0xAA@0x555, 0x55@0x2AA and 0x90 at an address in bank B, reads of bank B return identification bytes in bits 7:0 with bits 31:8 zero. The offsets and their bytes are: 0x00 gives 0x01, 0x01 gives 0xFE, 0x0E gives 0xA1 and 0x0F gives 0x80. Any other offset in bank B reads 0.
- R7: Every identification byte has an odd number of one bits, and bit 7 is the parity bit.
- R8: During identification mode, reads of the other bank return array data. The mode stays active through reads and through writes whose low byte is not 0xF0.
- R9: While a program runs, every write is ignored. A read of the programming bank returns a status word: bit 7 is the inverse of bit 7 of the data being programmed, bit 5 is the error flag, bit 6 is the toggle bit and all other bits are 0.
- R10: Bit 6 of the status word is 0 on the first status read of a program and flips on each later status read of that program.
- R11: While a program runs, reads of the other bank return array data.
- R12: A program stores old AND new. If the new data has a 1 where the stored word has a 0, the error flag (status bit 5) is 1 for that program and the stored 0 stays 0.
- R13: When `acc_en` is 1 in the read state, outside identification mode, one write programs the full word at its address with no unlock cycles. The timing is the same as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Bank bit (MSB) and in-bank offset |
| wdata | input | DATA_W | Write data; bits 7:0 carry command codes |
| acc_en | input | 1 | Enables single-write accelerated programming |
| rdata | output | DATA_W | Read result, registered |
| ready | output | 1 | 1 when no program is running |

## Verification
The assertions assume that the host never raises `rd_en` and `wr_en` in the same cycle, and that `acc_en` changes only while no write is strobed. The bench drives every operation from one task at a time, separated by idle cycles, so the two strobes are never high together. It also changes `acc_en` only between operations. Reads during a program are placed so that each status read falls inside the busy window. A write is also issued there to exercise the ignore rule.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PSET,
        ST_BUSY
    } seq_state_e;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam logic [15:0] OFFS_UNLOCK_A = 16'h0555;
    localparam logic [15:0] OFFS_UNLOCK_B = 16'h02AA;

    // bit 7 makes the byte's count of ones odd
    function automatic logic [7:0] odd_parity_byte(input logic [6:0] low7);
        return {~^low7, low7};
    endfunction

endpackage

// File: rtl/flash_word_array.sv
module flash_word_array #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic [DATA_W-1:0] commit_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            mem_d[commit_idx] = mem_q[commit_idx] & commit_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '1};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R12: a committed word never gains a one bit
    a_r12_and_only: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((mem_q[$past(commit_idx)] & ~$past(mem_q[commit_idx])) == '0));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 5,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] old_word,
    output logic              busy,
    output logic              busy_bank,
    output logic              prog_start,
    output logic              commit,
    output logic [IDX_W-1:0]  prog_idx,
    output logic [DATA_W-1:0] prog_data,
    output logic              prog_err,
    output logic              ident_on,
    output logic              ident_bank
);
    localparam int OFF_W = ADDR_W - 1;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  pidx;
        logic [DATA_W-1:0] pdata;
        logic              perr;
        logic              pbank;
        logic              ident;
        logic              ibank;
    } fsm_t;

    fsm_t r_q, r_d;

    logic [OFF_W-1:0] off;
    logic [7:0]       code;
    logic             is_unl_a, is_unl_b;

    assign off      = addr[OFF_W-1:0];
    assign code     = wdata[7:0];
    assign is_unl_a = (code == CMD_UNLOCK_A) && (off == OFFS_UNLOCK_A[OFF_W-1:0]);
    assign is_unl_b = (code == CMD_UNLOCK_B) && (off == OFFS_UNLOCK_B[OFF_W-1:0]);

    always_comb begin
        r_d        = r_q;
        prog_start = 1'b0;
        commit     = 1'b0;
        if (r_q.state == ST_BUSY) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
            if (r_q.cnt == CNT_W'(1)) begin
                commit    = 1'b1;
                r_d.state = ST_READ;
            end
        end else if (wr_en) begin
            if (r_q.ident) begin
                if (code == CMD_RESET) begin
                    r_d.ident = 1'b0;
                end
            end else begin
                unique case (r_q.state)
                    ST_READ: begin
                        if (acc_en) begin
                            prog_start = 1'b1;
                        end else if (is_unl_a) begin
                            r_d.state = ST_UNL1;
                        end
                    end
                    ST_UNL1: r_d.state = is_unl_b ? ST_UNL2 : ST_READ;
                    ST_UNL2: begin
                        r_d.state = ST_READ;
                        if (code == CMD_PROGRAM) begin
                            r_d.state = ST_PSET;
                        end else if (code == CMD_IDENT) begin
                            r_d.ident = 1'b1;
                            r_d.ibank = addr[ADDR_W-1];
                        end
                    end
                    ST_PSET: prog_start = 1'b1;
                    default: r_d.state = ST_READ;
                endcase
            end
        end
        if (prog_start) begin
            r_d.state = ST_BUSY;
            r_d.cnt   = CNT_W'(PROG_CYCLES);
            r_d.pidx  = wr_idx;
            r_d.pdata = wdata;
            r_d.perr  = |(wdata & ~old_word);
            r_d.pbank = addr[ADDR_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_READ, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state == ST_BUSY);
    assign busy_bank  = r_q.pbank;
    assign prog_idx   = r_q.pidx;
    assign prog_data  = r_q.pdata;
    assign prog_err   = r_q.perr;
    assign ident_on   = r_q.ident;
    assign ident_bank = r_q.ibank;

    // R9: writes during a program leave the running operation untouched
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cnt > CNT_W'(1)) |=> (busy && $stable(r_q.pdata) && $stable(r_q.pidx)));

    // R8: identification mode persists until a 0xF0 write
    a_r8_ident_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ident && !(wr_en && code == CMD_RESET)) |=> (r_q.ident && $stable(r_q.ibank)));

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [6:0]  MFR_LOW7 = 7'h01,
    parameter logic [6:0]  ID0_LOW7 = 7'h7E,
    parameter logic [6:0]  ID1_LOW7 = 7'h21,
    parameter logic [6:0]  ID2_LOW7 = 7'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] arr_word,
    input  logic              busy,
    input  logic              busy_bank,
    input  logic              prog_bit7,
    input  logic              prog_err,
    input  logic              prog_start,
    input  logic              ident_on,
    input  logic              ident_bank,
    output logic [DATA_W-1:0] rdata
);
    localparam int OFF_W = ADDR_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tog;
    } rp_t;

    rp_t r_q, r_d;

    logic             bank;
    logic [OFF_W-1:0] off;
    logic             stat_rd, ident_rd;
    logic [7:0]       ident_byte;

    assign bank     = addr[ADDR_W-1];
    assign off      = addr[OFF_W-1:0];
    assign stat_rd  = rd_en && busy && (bank == busy_bank);
    assign ident_rd = rd_en && ident_on && (bank == ident_bank);

    always_comb begin
        unique case (off)
            OFF_W'(8'h00): ident_byte = odd_parity_byte(MFR_LOW7);
            OFF_W'(8'h01): ident_byte = odd_parity_byte(ID0_LOW7);
            OFF_W'(8'h0E): ident_byte = odd_parity_byte(ID1_LOW7);
            OFF_W'(8'h0F): ident_byte = odd_parity_byte(ID2_LOW7);
            default:       ident_byte = 8'h00;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (prog_start) begin
            r_d.tog = 1'b0;
        end
        if (stat_rd) begin
            r_d.rdata = '0;
            r_d.rdata[7:5] = {~prog_bit7, r_q.tog, prog_err};
            r_d.tog = ~r_q.tog;
        end else if (ident_rd) begin
            r_d.rdata = {{(DATA_W-8){1'b0}}, ident_byte};
        end else if (rd_en) begin
            r_d.rdata = arr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.rdata;

    // R2: output holds while no read is strobed
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(r_q.rdata));

    // R10: back-to-back status reads see opposite toggle bits
    a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd ##1 stat_rd) |=> (r_q.rdata[6] != $past(r_q.rdata[6])));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          BANK_WORDS  = 16,
    parameter int          PROG_CYCLES = 8,
    parameter logic [6:0]  MFR_LOW7    = 7'h01,
    parameter logic [6:0]  ID0_LOW7    = 7'h7E,
    parameter logic [6:0]  ID1_LOW7    = 7'h21,
    parameter logic [6:0]  ID2_LOW7    = 7'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              acc_en,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    localparam int LOW_W = $clog2(BANK_WORDS);
    localparam int IDX_W = LOW_W + 1;

    logic [IDX_W-1:0]  word_idx, prog_idx;
    logic [DATA_W-1:0] arr_word, prog_data;
    logic busy, busy_bank, prog_start, commit, prog_err, ident_on, ident_bank;

    assign word_idx = {addr[ADDR_W-1], addr[LOW_W-1:0]};

    flash_word_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_idx(prog_idx), .commit_data(prog_data),
        .rd_idx(word_idx), .rd_word(arr_word)
    );

    flash_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_en(acc_en),
        .addr(addr), .wdata(wdata), .wr_idx(word_idx), .old_word(arr_word),
        .busy(busy), .busy_bank(busy_bank), .prog_start(prog_start), .commit(commit),
        .prog_idx(prog_idx), .prog_data(prog_data), .prog_err(prog_err),
        .ident_on(ident_on), .ident_bank(ident_bank)
    );

    flash_read_path #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .MFR_LOW7(MFR_LOW7), .ID0_LOW7(ID0_LOW7), .ID1_LOW7(ID1_LOW7), .ID2_LOW7(ID2_LOW7)
    ) u_read (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .arr_word(arr_word),
        .busy(busy), .busy_bank(busy_bank), .prog_bit7(prog_data[7]), .prog_err(prog_err),
        .prog_start(prog_start), .ident_on(ident_on), .ident_bank(ident_bank),
        .rdata(rdata)
    );

    assign ready = ~busy;

    // R3: accepting a program word drops ready on the next cycle
    a_r3_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !ready);

    // R13: a write taken as a program while ready is never dropped
    a_r13_acc_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_en && ready && !ident_on && $past(ready) && !$past(wr_en)) |=> !ready);

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, acc_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ready;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .acc_en(acc_en), .rdata(rdata), .ready(ready)
    );

    function automatic logic [7:0] par(input logic [6:0] v);
        par = {($countones(v) % 2) == 0, v};
    endfunction

    function automatic logic [31:0] ident_exp(input logic [10:0] off);
        case (off)
            11'h000: ident_exp = {24'h0, par(7'h01)};
            11'h001: ident_exp = {24'h0, par(7'h7E)};
            11'h00E: ident_exp = {24'h0, par(7'h21)};
            11'h00F: ident_exp = {24'h0, par(7'h00)};
            default: ident_exp = 32'h0;
        endcase
    endfunction

    // behavioural reference model
    logic [31:0] m_mem [0:31];
    int          m_mode, m_cnt;
    bit          m_busy, m_perr, m_pbank, m_asel, m_abank, m_tog;
    logic [4:0]  m_pidx;
    logic [31:0] m_pdata, m_rdata;

    always @(posedge clk) begin
        logic [4:0] idx;
        logic [7:0] c;
        bit start;
        idx = {addr[11], addr[3:0]};
        c = wdata[7:0];
        start = 0;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_mem[i] = '1;
            m_mode = 0; m_busy = 0; m_asel = 0; m_tog = 0; m_rdata = 0; m_cnt = 0;
        end else begin
            if (rd_en) begin
                if (m_busy && addr[11] == m_pbank) begin
                    m_rdata = {24'h0, ~m_pdata[7], m_tog, m_perr, 5'h0};
                    m_tog = ~m_tog;
                end else if (m_asel && addr[11] == m_abank) m_rdata = ident_exp(addr[10:0]);
                else m_rdata = m_mem[idx];
            end
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_mem[m_pidx] = m_mem[m_pidx] & m_pdata;
                    m_busy = 0;
                end
            end else if (wr_en) begin
                if (m_asel) begin
                    if (c == 8'hF0) m_asel = 0;
                end else begin
                    case (m_mode)
                        0: if (acc_en) start = 1;
                           else if (c == 8'hAA && addr[10:0] == 11'h555) m_mode = 1;
                        1: m_mode = (c == 8'h55 && addr[10:0] == 11'h2AA) ? 2 : 0;
                        2: begin
                            m_mode = 0;
                            if (c == 8'hA0) m_mode = 3;
                            else if (c == 8'h90) begin m_asel = 1; m_abank = addr[11]; end
                        end
                        default: start = 1;
                    endcase
                end
                if (start) begin
                    m_perr = |(wdata & ~m_mem[idx]);
                    m_pdata = wdata; m_pidx = idx; m_pbank = addr[11];
                    m_busy = 1; m_cnt = 8; m_tog = 0; m_mode = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model rdata", rdata, m_rdata);
            chk("R3 model ready", {31'h0, ready}, {31'h0, !m_busy});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic prog_seq(input logic [11:0] a, input logic [31:0] d);
        wr(12'h555, 32'hAA); wr(12'h2AA, 32'h55); wr(12'h000, 32'hA0); wr(a, d);
    endtask

    task automatic wait_ready;
        while (!ready) @(negedge clk);
    endtask

    task automatic report;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'h0, ready}, 32'h1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready after reset", {31'h0, ready}, 32'h1);
        chk("R1 rdata after reset", rdata, 32'h0);
        rd_chk("R1 erased word", 12'h005, 32'hFFFF_FFFF);

        // program sequence, status and other bank
        prog_seq(12'h003, 32'h1234_5678);
        chk("R3 ready low after data write", {31'h0, ready}, 32'h0);
        rd_chk("R9 first status", 12'h003, 32'h0000_0080);
        rd_chk("R10 second status toggles", 12'h0A0, 32'h0000_00C0);
        wr(12'h555, 32'hAA);
        rd_chk("R11 other bank during program", 12'h803, 32'hFFFF_FFFF);
        wait_ready();
        rd_chk("R3 programmed word", 12'h003, 32'h1234_5678);
        rd_chk("R2 aliased index", 12'h013, 32'h1234_5678);
        wr(12'h2AA, 32'h55); wr(12'h000, 32'hA0); wr(12'h004, 32'h0);
        chk("R9 write during program ignored", {31'h0, ready}, 32'h1);
        rd_chk("R9 untouched word", 12'h004, 32'hFFFF_FFFF);

        // AND-only with error flag
        prog_seq(12'h003, 32'hFF00_0000);
        rd_chk("R12 error flag in status", 12'h003, 32'h0000_00A0);
        wait_ready();
        rd_chk("R12 stored AND", 12'h003, 32'h1200_0000);

        // broken sequence
        wr(12'h555, 32'hAA); wr(12'h2AA, 32'h56); wr(12'h000, 32'hA0); wr(12'h006, 32'h0);
        chk("R4 no program after bad cycle", {31'h0, ready}, 32'h1);
        rd_chk("R4 word unchanged", 12'h006, 32'hFFFF_FFFF);

        // identification on bank 1
        wr(12'h555, 32'hAA); wr(12'h2AA, 32'h55); wr(12'h800, 32'h90);
        rd_chk("R6 manufacturer", 12'h800, ident_exp(11'h000));
        rd_chk("R6 id byte 0", 12'h801, ident_exp(11'h001));
        rd_chk("R6 id byte 1", 12'h80E, ident_exp(11'h00E));
        rd(12'h80F, v);
        chk("R6 id byte 2", v, ident_exp(11'h00F));
        chk("R7 odd parity", {31'h0, 1'($countones(v[7:0]) % 2)}, 32'h1);
        chk("R7 fixed byte 0xFE", ident_exp(11'h001), 32'h0000_00FE);
        rd_chk("R6 other offset zero", 12'h802, 32'h0);
        rd_chk("R8 other bank array", 12'h003, 32'h1200_0000);
        wr(12'h555, 32'hAA);
        rd_chk("R8 mode persists", 12'h800, ident_exp(11'h000));
        wr(12'h000, 32'hF0);
        rd_chk("R5 reset exits identification", 12'h800, 32'hFFFF_FFFF);
        wr(12'h555, 32'hAA); wr(12'h000, 32'hF0); wr(12'h000, 32'hA0); wr(12'h007, 32'h0);
        chk("R5 reset inside unlock", {31'h0, ready}, 32'h1);

        // accelerated single write
        @(negedge clk); acc_en = 1;
        wr(12'h807, 32'h0F0F_0F0F);
        chk("R13 accelerated busy", {31'h0, ready}, 32'h0);
        wait_ready();
        @(negedge clk); acc_en = 0;
        rd_chk("R13 accelerated word", 12'h807, 32'h0F0F_0F0F);

        // reset during program
        prog_seq(12'h009, 32'h0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 reset aborts program", {31'h0, ready}, 32'h1);
        rd_chk("R1 array erased", 12'h003, 32'hFFFF_FFFF);
        repeat (10) @(negedge clk);
        report();
    end

endmodule